// File: doc/BRIEF.md
# Head Load and Unload Sequencer

This block drives the head-load line of a floppy drive around each read or write. A request strobe starts a sequence. First comes a short fault-clear pulse to the drive with the head still lifted. Then the head is loaded, and the block counts a programmable settle time in millisecond ticks. Only after that count does it raise a flag that tells the transfer engine it may move data.

When the transfer engine strobes completion, the flag drops at once. The head stays loaded for a programmable hold-off time and is then released. A request that arrives during the hold-off reuses the loaded head. It goes straight to ready without a new fault-clear pulse and without a new settle wait.

Both waits are counted from an external 1 ms tick. The settle code `n` (7 bits) gives 2·n ticks. The hold-off code `m` (4 bits) gives 16·m ticks. A zero code acts like a code of one. The codes are plain inputs held by the surrounding logic, so reset never disturbs them.

Top module: `head_load_timer`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `headLoad`, `faultReset` and `xferReady` are all 0. A reset in the middle of a sequence returns all three to 0.
- R2: A one-cycle `opReq` while idle makes `faultReset` high for exactly 4 clocks (parameter FRST_CYCLES), starting the clock after the strobe. `headLoad` stays low during the pulse and is high in the clock right after the pulse ends.
- R3: After the fault-clear pulse, `xferReady` stays low while `headLoad` is high for 2·n ms ticks, where n is `loadCode` and 0 counts as 1. `xferReady` goes high in the clock after the tick that completes the count.
- R4: An `opDone` strobe while ready clears `xferReady` in the next clock. `headLoad` then stays high for 16·m ms ticks, where m is `unloadCode` and 0 counts as 1, and drops in the clock after the final tick.
- R5: An `opReq` during the hold-off sets `xferReady` in the next clock, with no `faultReset` pulse and with `headLoad` staying high. A later `opDone` starts a full new hold-off count.
- R6: If `opReq` arrives in the same cycle as the tick that would end the hold-off, the reuse wins: `xferReady` and `headLoad` are both high in the next clock.
- R7: Each wait uses the code present at the clock where that wait begins. Changing `loadCode` or `unloadCode` during a wait does not change its length.
- R8: Strobes that do not fit the current phase are ignored. `opReq` during the pulse, the settle wait or the ready phase has no effect. `opDone` while idle or during the settle wait has no effect. Ticks that arrive during the fault-clear pulse are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse every millisecond |
| opReq | input | 1 | Read/write request strobe |
| opDone | input | 1 | Transfer finished strobe |
| loadCode | input | 7 | Settle-time code, 2 ms per step |
| unloadCode | input | 4 | Hold-off code, 16 ms per step |
| headLoad | output | 1 | Head-load line to the drive |
| faultReset | output | 1 | Fault-clear pulse to the drive |
| xferReady | output | 1 | Head settled, data may move |

## Verification
The bench sweeps code pairs that include zero codes and the all-ones codes. Getting either count off by one tick, or not clamping zero, would give a settle or hold-off length the bench rejects.

It aims a request at the hold-off window, and also at the exact tick that ends it. A design that gave expiry priority would drop the head and fire a new fault pulse there.

It changes a code in the middle of a wait. A design that read the codes live would stretch the wait.

It also sends stray strobes and ticks in the wrong phases. A design that honoured them would restart the pulse, shorten the settle, or count ticks during the pulse.

// File: rtl/hlt_pkg.sv
package hlt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FRST   = 3'd1,
    ST_LOAD   = 3'd2,
    ST_READY  = 3'd3,
    ST_UNLOAD = 3'd4
  } hlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic frstArm;    // start the fault-clear pulse counter
    logic frstRun;    // pulse counter is active
    logic loadArm;    // load the tick counter with the settle target
    logic unloadArm;  // load the tick counter with the hold-off target
    logic counting;   // tick counter consumes msTick
  } hlCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic frstDone;   // last cycle of the fault-clear pulse
    logic expire;     // tick that completes the current wait
  } hlStat_t;

endpackage

// File: rtl/hl_timer_dp.sv
module hl_timer_dp
  import hlt_pkg::*;
#(
  parameter int LOAD_CODE_W   = 7,
  parameter int UNLOAD_CODE_W = 4,
  parameter int LOAD_STEP     = 2,
  parameter int UNLOAD_STEP   = 16,
  parameter int FRST_CYCLES   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     msTick,
  input  logic [LOAD_CODE_W-1:0]   loadCode,
  input  logic [UNLOAD_CODE_W-1:0] unloadCode,
  input  hlCtl_t                   ctl,
  output hlStat_t                  stat
);

  localparam int LOAD_MAX   = ((1 << LOAD_CODE_W) - 1) * LOAD_STEP;
  localparam int UNLOAD_MAX = ((1 << UNLOAD_CODE_W) - 1) * UNLOAD_STEP;
  localparam int TICK_MAX   = (LOAD_MAX > UNLOAD_MAX) ? LOAD_MAX : UNLOAD_MAX;
  localparam int CNT_W      = $clog2(TICK_MAX + 1);
  localparam int FRST_W     = (FRST_CYCLES > 1) ? $clog2(FRST_CYCLES) : 1;

  logic [CNT_W-1:0]  tickCnt;
  logic [CNT_W-1:0]  loadUnits, unloadUnits;
  logic [CNT_W-1:0]  loadTarget, unloadTarget;
  logic [FRST_W-1:0] frstCnt;

  // zero codes behave as the smallest step
  always_comb begin
    loadUnits    = (loadCode   == '0) ? CNT_W'(1) : CNT_W'(loadCode);
    unloadUnits  = (unloadCode == '0) ? CNT_W'(1) : CNT_W'(unloadCode);
    loadTarget   = loadUnits   * CNT_W'(LOAD_STEP);
    unloadTarget = unloadUnits * CNT_W'(UNLOAD_STEP);
  end

  // millisecond down-counter shared by both waits
  always_ff @(posedge clk) begin
    if (!rst_n)
      tickCnt <= '0;
    else if (ctl.loadArm)
      tickCnt <= loadTarget;
    else if (ctl.unloadArm)
      tickCnt <= unloadTarget;
    else if (ctl.counting && msTick && tickCnt > CNT_W'(1))
      tickCnt <= tickCnt - CNT_W'(1);
  end

  // fault-clear pulse length counter
  always_ff @(posedge clk) begin
    if (!rst_n)
      frstCnt <= '0;
    else if (ctl.frstArm)
      frstCnt <= FRST_W'(FRST_CYCLES - 1);
    else if (ctl.frstRun && frstCnt != '0)
      frstCnt <= frstCnt - FRST_W'(1);
  end

  always_comb begin
    stat.expire   = ctl.counting && msTick && (tickCnt == CNT_W'(1));
    stat.frstDone = ctl.frstRun && (frstCnt == '0);
  end

  // R3
  // counter is never empty while a wait is in progress
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.counting |-> (tickCnt != '0));

endmodule

// File: rtl/hl_timer_ctl.sv
module hl_timer_ctl
  import hlt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    opReq,
  input  logic    opDone,
  input  hlStat_t stat,
  output hlCtl_t  ctl,
  output logic    headLoad,
  output logic    faultReset,
  output logic    xferReady
);

  hlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    ctl.frstRun  = (state == ST_FRST);
    ctl.counting = (state == ST_LOAD) || (state == ST_UNLOAD);
    unique case (state)
      ST_IDLE: if (opReq) begin
        stateNext   = ST_FRST;
        ctl.frstArm = 1'b1;
      end
      ST_FRST: if (stat.frstDone) begin
        stateNext   = ST_LOAD;
        ctl.loadArm = 1'b1;
      end
      ST_LOAD: if (stat.expire) stateNext = ST_READY;
      ST_READY: if (opDone) begin
        stateNext     = ST_UNLOAD;
        ctl.unloadArm = 1'b1;
      end
      ST_UNLOAD: begin
        if (opReq)            stateNext = ST_READY;  // reuse beats expiry
        else if (stat.expire) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      headLoad   <= 1'b0;
      faultReset <= 1'b0;
      xferReady  <= 1'b0;
    end else begin
      state      <= stateNext;
      headLoad   <= (stateNext == ST_LOAD) || (stateNext == ST_READY) ||
                    (stateNext == ST_UNLOAD);
      faultReset <= (stateNext == ST_FRST);
      xferReady  <= (stateNext == ST_READY);
    end
  end

  // R2
  frst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(faultReset && headLoad));

  // R2
  load_after_frst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(headLoad) |-> $past(faultReset));

  // R3
  ready_needs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xferReady |-> headLoad);

  // R5
  reuse_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UNLOAD && opReq) |=> (xferReady && !faultReset));

  // R4
  unload_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(headLoad) |-> !xferReady);

endmodule

// File: rtl/head_load_timer.sv
module head_load_timer
  import hlt_pkg::*;
#(
  parameter int LOAD_CODE_W   = 7,
  parameter int UNLOAD_CODE_W = 4,
  parameter int LOAD_STEP     = 2,
  parameter int UNLOAD_STEP   = 16,
  parameter int FRST_CYCLES   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     msTick,
  input  logic                     opReq,
  input  logic                     opDone,
  input  logic [LOAD_CODE_W-1:0]   loadCode,
  input  logic [UNLOAD_CODE_W-1:0] unloadCode,
  output logic                     headLoad,
  output logic                     faultReset,
  output logic                     xferReady
);

  hlCtl_t  ctl;
  hlStat_t stat;

  hl_timer_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .opReq      (opReq),
    .opDone     (opDone),
    .stat       (stat),
    .ctl        (ctl),
    .headLoad   (headLoad),
    .faultReset (faultReset),
    .xferReady  (xferReady)
  );

  hl_timer_dp #(
    .LOAD_CODE_W   (LOAD_CODE_W),
    .UNLOAD_CODE_W (UNLOAD_CODE_W),
    .LOAD_STEP     (LOAD_STEP),
    .UNLOAD_STEP   (UNLOAD_STEP),
    .FRST_CYCLES   (FRST_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .msTick     (msTick),
    .loadCode   (loadCode),
    .unloadCode (unloadCode),
    .ctl        (ctl),
    .stat       (stat)
  );

endmodule

// File: tb/tb_head_load_timer.sv
module tb_head_load_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msTick = 1'b0;
  logic       opReq = 1'b0;
  logic       opDone = 1'b0;
  logic [6:0] loadCode = 7'd1;
  logic [3:0] unloadCode = 4'd1;
  logic       headLoad, faultReset, xferReady;

  int nChecks = 0;
  int nFail   = 0;
  bit ended   = 1'b0;

  // columns: loadCode, unloadCode, expected settle ticks, expected hold-off ticks
  localparam int NVEC = 5;
  localparam int VEC [NVEC][4] = '{
    '{1,   1,  2,   16},
    '{0,   0,  2,   16},
    '{5,   3,  10,  48},
    '{127, 15, 254, 240},
    '{64,  2,  128, 32}
  };

  always #10 clk = ~clk;

  head_load_timer dut (
    .clk(clk), .rst_n(rst_n), .msTick(msTick), .opReq(opReq), .opDone(opDone),
    .loadCode(loadCode), .unloadCode(unloadCode),
    .headLoad(headLoad), .faultReset(faultReset), .xferReady(xferReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tick();
    msTick = 1'b1; cyc(); msTick = 1'b0;
    repeat (3) cyc();
  endtask

  task automatic req();
    opReq = 1'b1; cyc(); opReq = 1'b0;
  endtask

  task automatic done();
    opDone = 1'b1; cyc(); opDone = 1'b0;
  endtask

  task automatic countLoad(inout int n);
    while (!xferReady && n < 400) begin
      tick(); n++;
    end
  endtask

  task automatic countUnload(inout int n);
    while (headLoad && n < 400) begin
      tick(); n++;
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int n;
    int w;
    bit bad;
    repeat (3) cyc();
    // R1 reset state
    check(!headLoad && !faultReset && !xferReady, "R1 in reset",
          {headLoad, faultReset, xferReady}, 0);
    rst_n = 1'b1; cyc();
    check(!headLoad && !faultReset && !xferReady, "R1 after reset",
          {headLoad, faultReset, xferReady}, 0);

    // vector sweep: R2, R3, R4
    for (int v = 0; v < NVEC; v++) begin
      loadCode   = 7'(VEC[v][0]);
      unloadCode = 4'(VEC[v][1]);
      req();
      w = 0; bad = 1'b0;
      while (faultReset && w < 20) begin
        if (headLoad) bad = 1'b1;
        w++; cyc();
      end
      check(w == 4 && !bad, "R2 pulse width", w, 4);
      check(headLoad == 1'b1, "R2 head after pulse", headLoad, 1);
      n = 0; countLoad(n);
      check(n == VEC[v][2], "R3 settle ticks", n, VEC[v][2]);
      done();
      check(!xferReady && headLoad, "R4 ready drop", xferReady, 0);
      n = 0; countUnload(n);
      check(n == VEC[v][3], "R4 hold-off ticks", n, VEC[v][3]);
    end

    // R5 reuse during hold-off, then full reload
    loadCode = 7'd1; unloadCode = 4'd2;
    req(); while (faultReset) cyc();
    n = 0; countLoad(n);
    done();
    repeat (5) tick();
    req();
    check(xferReady && headLoad && !faultReset, "R5 reuse",
          {xferReady, headLoad, faultReset}, 6);
    done();
    n = 0; countUnload(n);
    check(n == 32, "R5 fresh hold-off", n, 32);

    // R6 request on the expiring tick
    req(); while (faultReset) cyc();
    n = 0; countLoad(n);
    done();
    repeat (31) tick();
    msTick = 1'b1; opReq = 1'b1; cyc(); msTick = 1'b0; opReq = 1'b0;
    check(xferReady && headLoad && !faultReset, "R6 reuse wins",
          {xferReady, headLoad, faultReset}, 6);
    done();
    n = 0; countUnload(n);

    // R7 code change mid-wait
    loadCode = 7'd3;
    req(); while (faultReset) cyc();
    tick(); tick();
    loadCode = 7'd100;
    n = 2; countLoad(n);
    check(n == 6, "R7 settle uses captured code", n, 6);
    unloadCode = 4'd1;
    done();
    tick();
    unloadCode = 4'd9;
    n = 1; countUnload(n);
    check(n == 16, "R7 hold-off uses captured code", n, 16);

    // R8 stray strobes and ticks
    loadCode = 7'd2; unloadCode = 4'd1;
    done();
    check(!headLoad && !faultReset, "R8 done while idle", headLoad, 0);
    req();
    tick();   // lands inside the fault pulse
    while (faultReset) cyc();
    tick();
    req();    // ignored during settle
    done();   // ignored during settle
    check(!faultReset && headLoad && !xferReady, "R8 strobes in settle",
          {faultReset, headLoad, xferReady}, 2);
    n = 1; countLoad(n);
    check(n == 4, "R8 settle unaffected", n, 4);
    req();
    check(xferReady && !faultReset, "R8 req while ready", {xferReady, faultReset}, 2);

    // R1 reset mid-sequence
    rst_n = 1'b0; cyc();
    rst_n = 1'b1; cyc();
    check(!headLoad && !faultReset && !xferReady, "R1 mid-sequence reset",
          {headLoad, faultReset, xferReady}, 0);

    finishRun();
  end

endmodule